// File: doc/BRIEF.md
# Crossbar Column Output Arbiter with Remove-Request Priority

This block makes the decisions for one output port of an N-input buffered crossbar. Each input owns one crosspoint buffer in the column that feeds this output. In every cell slot (every clock cycle) the block looks at two N-bit vectors: which of those buffers currently hold a cell, and which inputs are asking to have their cell removed. From these it picks at most one buffer to drain onto the output link.

Inputs that raise a remove-request are served ahead of plain round-robin service. A remove-request only counts when the buffer it names actually holds a cell. Both kinds of service use one rotating priority pointer. The search for a winner starts at the pointer and wraps around. After a cell is served, the pointer moves to the position just past the winner. At the same time, a one-hot notification goes back to the winning input so it can update its record of how full its crosspoint buffers are.

The decision is combinational from the current inputs and the registered pointer. The pointer itself changes at the clock edge that closes the slot.

Top module: `rrs_out_sched`

## Requirements
- R1: Out of reset the pointer is 0, so the first slot with every buffer occupied and no requests serves input 0.
- R2: When at least one input has a remove-request on an occupied buffer, `serve_vld_o` is 1 and the served input is one whose remove-request is set.
- R3: Among inputs that have a remove-request on an occupied buffer, the winner is the first one found when scanning upward from the pointer and wrapping from N-1 to 0.
- R4: A remove-request on an empty buffer is ignored. If every request targets an empty buffer, service falls back to plain round-robin over the occupied buffers.
- R5: When no request is valid, the winner is the first occupied buffer found when scanning upward from the pointer with wrap-around.
- R6: After a slot in which a cell is served, the pointer holds the served index plus one. After index N-1 it wraps to 0.
- R7: `serve_idx_o` gives the binary index of the served input. `notify_o` has exactly the bit at that index set when a cell is served and is all zero otherwise.
- R8: In a slot with no occupied buffer, `serve_vld_o` and `notify_o` are 0 whatever the requests are, and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cell slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| occ_i | input | N | Bit i set when input i's crosspoint buffer in this column holds a cell |
| rmv_req_i | input | N | Bit i set when input i asks for its cell to be removed |
| serve_vld_o | output | 1 | A cell is sent to the output link in this slot |
| serve_idx_o | output | $clog2(N) | Binary index of the served input |
| notify_o | output | N | One-hot delivery notice to the served input |

## Verification
The bench builds the arbiter with N = 5. This is not a power of two, so the pointer must wrap from 4 to 0 explicitly, and index values 5 to 7 are unused and must never appear. With five inputs, a few hundred random slots reach every pointer position together with many request and occupancy mixes, including requests that name empty buffers. Directed slots cover the reset pick, a remove-request that sits below the pointer, masked-only requests, the wrap, and idle slots that carry requests.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  // Position of the set bit in a one-hot word (0 when the word is empty).
  function automatic int oh_to_idx(input logic [31:0] v);
    int r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Pointer position after serving input idx among n inputs.
  function automatic int step_ptr(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/rrs_rot_pick.sv
module rrs_rot_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  grant,
  output logic          any
);
  logic [N-1:0] at_or_above;
  logic [N-1:0] hi_req;
  logic [N-1:0] cand;
  logic [N-1:0] seen;

  for (genvar i = 0; i < N; i++) begin : g_mask
    assign at_or_above[i] = (ptr <= IW'(i));
  end

  assign hi_req = req & at_or_above;
  assign cand   = (|hi_req) ? hi_req : req;

  // lowest-set-bit chain over the chosen half
  assign seen[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign seen[i] = seen[i-1] | cand[i-1];
  end
  for (genvar i = 0; i < N; i++) begin : g_grant
    assign grant[i] = cand[i] & ~seen[i];
  end

  assign any = |req;

endmodule

// File: rtl/rrs_ptr_reg.sv
module rrs_ptr_reg #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [IW-1:0] nxt,
  output logic [IW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= nxt;
  end
endmodule

// File: rtl/rrs_out_sched.sv
module rrs_out_sched #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         occ_i,
  input  logic [N-1:0]         rmv_req_i,
  output logic                 serve_vld_o,
  output logic [$clog2(N)-1:0] serve_idx_o,
  output logic [N-1:0]         notify_o
);
  import rrs_pkg::*;

  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr;
  logic [IW-1:0] ptr_nxt;
  logic [N-1:0]  valid_rm;
  logic [N-1:0]  g_rm, g_rr;
  logic          any_rm, any_rr;

  // requests on empty buffers are dropped here
  assign valid_rm = rmv_req_i & occ_i;

  rrs_rot_pick #(.N(N), .IW(IW)) u_pick_rm (
    .req(valid_rm), .ptr(ptr), .grant(g_rm), .any(any_rm)
  );

  rrs_rot_pick #(.N(N), .IW(IW)) u_pick_rr (
    .req(occ_i), .ptr(ptr), .grant(g_rr), .any(any_rr)
  );

  assign notify_o    = any_rm ? g_rm : g_rr;
  assign serve_vld_o = any_rm | any_rr;
  assign serve_idx_o = IW'(oh_to_idx(32'(notify_o)));
  assign ptr_nxt     = IW'(step_ptr(int'(serve_idx_o), N));

  rrs_ptr_reg #(.IW(IW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(serve_vld_o), .nxt(ptr_nxt), .ptr(ptr)
  );

  // ---------------- assertions ----------------
  p_req_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rmv_req_i & occ_i)) |-> (serve_vld_o && rmv_req_i[serve_idx_o]));

  p_served_occupied_r4: assert property (@(posedge clk) disable iff (!rst_n)
    serve_vld_o |-> occ_i[serve_idx_o]);

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    serve_vld_o |=> (($past(serve_idx_o) == IW'(N-1)) ? (ptr == '0)
                                                      : (ptr == $past(serve_idx_o) + 1'b1)));

  p_notify_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(notify_o) && (serve_vld_o == (|notify_o)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|occ_i) |-> (!serve_vld_o && notify_o == '0));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|occ_i) |=> $stable(ptr));

endmodule

// File: tb/test_rrs_out_sched.sv
`timescale 1ns/1ps
module test_rrs_out_sched;
  localparam int N  = 5;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  occ = '0;
  logic [N-1:0]  req = '0;
  logic          vld;
  logic [IW-1:0] idx;
  logic [N-1:0]  ntf;

  int errs = 0;
  int checks = 0;
  int m_ptr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rrs_out_sched #(.N(N)) i_rrs_out_sched (
    .clk(clk), .rst_n(rst_n), .occ_i(occ), .rmv_req_i(req),
    .serve_vld_o(vld), .serve_idx_o(idx), .notify_o(ntf)
  );

  function automatic int scan(input logic [N-1:0] v, input int p);
    for (int k = 0; k < N; k++) begin
      if (v[(p + k) % N]) return (p + k) % N;
    end
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic slot(input logic [N-1:0] o, input logic [N-1:0] r, input string tag_in);
    logic [N-1:0] vr;
    int win;
    string tag;
    @(negedge clk);
    occ = o;
    req = r;
    #1;
    vr = o & r;
    win = (vr != 0) ? scan(vr, m_ptr) : scan(o, m_ptr);
    if (tag_in != "") tag = tag_in;
    else if (o == 0) tag = "R8";
    else if (vr != 0) tag = "R3";
    else if (r != 0) tag = "R4";
    else tag = "R5";
    chk(tag, int'(vld), (win >= 0) ? 1 : 0, "serve_vld");
    if (win >= 0) chk(tag, int'(idx), win, "serve_idx");
    chk("R7", int'(ntf), (win >= 0) ? (1 << win) : 0, "notify");
    if (vr != 0) chk("R2", int'(r[idx]), 1, "served input requested");
    @(posedge clk);
    if (win >= 0) m_ptr = (win + 1) % N;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state, nothing occupied
    slot('0, '0, "R8");
    slot(5'b11111, 5'b00000, "R1");          // ptr 0 -> serve 0
    slot(5'b11111, 5'b00001, "R3");          // req below ptr wraps to 0
    slot(5'b01111, 5'b10000, "R4");          // request on empty buffer ignored
    slot(5'b11111, 5'b10100, "R3");          // ptr 2 -> serve 2
    slot(5'b10000, 5'b00000, "R6");          // serve 4, ptr wraps
    slot(5'b11111, 5'b00000, "R6");          // serve 0
    slot(5'b00000, 5'b11111, "R8");          // idle with requests
    slot(5'b11111, 5'b00000, "R8");          // pointer held at 1
    slot(5'b00110, 5'b11001, "R4");
    for (int n = 0; n < 400; n++) begin
      logic [N-1:0] o, r;
      o = N'($urandom);
      r = ($urandom % 3 == 0) ? '0 : (N'($urandom) & N'($urandom));
      if ($urandom % 10 == 0) o = '0;
      slot(o, r, "");
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule